// File: doc/BRIEF.md
# Buck Section Start-Up Sequencer and Protection Supervisor

This block is the digital supervisor for one section of a two-section synchronous buck controller. It decodes a two-bit enable level, orders start-up relative to the companion section, ramps the valley current limit in four equal steps during soft-start, and drives the discharge switch during soft-end. It also latches over-voltage, under-voltage and over-temperature faults, and it reports power-good. The output-window comparators, the over-temperature sensor and the supply monitors are analog. This block only consumes their single-bit flags.

Each section of the controller gets its own instance. Its `pgood` output goes to the other instance's `other_pgood` input. A section whose enable is set to the slaved code starts only when its partner is in regulation. It drops back to soft-end in the cycle after its partner loses regulation. The soft-start step period and the under-voltage arming delay are counted on a single timebase derived from the system clock. Both values are parameters.

Top module: `buck_seq_supervisor`

## Requirements
- R1: `en_code` 2'b00 means off. In the cycle after the clock edge that samples 00, `sw_en`=0, `ovp_pulldown`=0 and `dis_en`=1, and every latched fault is cleared. Codes 2'b01 and 2'b11 both mean "on" and start a soft-start on the next edge.
- R2: `en_code` 2'b10 means slaved. The section waits with `sw_en`=0 and `dis_en`=1 while `other_pgood` is low, and starts soft-start on the edge after `other_pgood` is seen high. If `other_pgood` falls while the section is switching, the section is in soft-end (`sw_en`=0, `dis_en`=1) after the next edge.
- R3: During soft-start `ilim_scale` reads 0, 1, 2 and then 3 (meaning 25%, 50%, 75% and 100%), each for STEP_CYCLES clocks. The section then enters regulation with `ilim_scale`=3.
- R4: Under-voltage protection is armed after UVP_ARM_TICKS step periods counted from the start of soft-start. Before that, `uv_flag` is ignored.
- R5: While the section is enabled and both supplies are good, `ov_flag` moves the section into a latched over-voltage state from any non-faulted state, including waiting and soft-start. In that state `ovp_pulldown`=1, `sw_en`=0, `dis_en`=0 and `ilim_scale`=3. The state holds until the section is disabled or a supply drops.
- R6: An armed under-voltage latches a soft-end (`sw_en`=0, `dis_en`=1) that persists after `uv_flag` clears, until the section is disabled.
- R7: When `pvcc_ok` is low, the section is off with `dis_en`=1 and all faults are cleared, without latching. When `pvcc_ok` returns with the enable still on, a new soft-start begins on the next edge.
- R8: `pgood` is high only while the section is in regulation with `pg_low_flag` and `ov_flag` both low. It is low throughout soft-start.
- R9: While `ref_ok` is low, the section cannot switch: it stays off with `dis_en`=1 and faults clear. It starts on the edge after `ref_ok` returns.
- R10: `ot_flag` latches a soft-end (`sw_en`=0, `dis_en`=1) that persists after `ot_flag` clears, until the enable is set to off.
- R11: When flags arrive together, over-voltage wins over over-temperature, and over-temperature wins over under-voltage. A latched fault ignores later fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_code | input | 2 | Enable level: 00 off, 01/11 on, 10 slaved |
| other_pgood | input | 1 | Power-good of the companion section |
| ov_flag | input | 1 | Output above the over-voltage threshold |
| uv_flag | input | 1 | Output below 70% of nominal |
| pg_low_flag | input | 1 | Output below 90% of nominal |
| pvcc_ok | input | 1 | Driver supply above its power-on-reset level |
| ref_ok | input | 1 | 3.3 V reference above its ready level |
| ot_flag | input | 1 | Over-temperature detected |
| ilim_scale | output | 2 | Current-limit scale: 0=25%, 1=50%, 2=75%, 3=100% |
| sw_en | output | 1 | Switching enable for the on-time controller |
| ovp_pulldown | output | 1 | Over-voltage pull-down request |
| dis_en | output | 1 | Internal output-discharge switch enable |
| pgood | output | 1 | Power-good |

## Verification
The bench checks the exact cycle of each current-limit step and the edge of under-voltage arming. It asserts `uv_flag` one cycle before arming and one cycle after. A design that arms a step period early or late either trips too soon or misses the fault. It checks that over-voltage, under-voltage and over-temperature stay latched after their flags clear, and that only disabling or a supply drop releases them. A design that tracked the flags would resume switching. The bench also drives all fault flags at once and drops the partner's power-good under a slaved enable. A wrong priority order shows up on `dis_en` and `ovp_pulldown`. A slave that did not follow its partner keeps switching.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAIT = 3'd1,
        ST_SOFT = 3'd2,
        ST_RUN  = 3'd3,
        ST_OVP  = 3'd4,
        ST_UVP  = 3'd5,
        ST_HOT  = 3'd6
    } sect_state_e;

    localparam logic [1:0] EN_OFF   = 2'b00;
    localparam logic [1:0] EN_ON    = 2'b01;
    localparam logic [1:0] EN_SLAVE = 2'b10;
    localparam logic [1:0] EN_ON_B  = 2'b11;

    localparam logic [1:0] SCALE_MIN  = 2'd0;
    localparam logic [1:0] SCALE_FULL = 2'd3;

    typedef struct packed {
        sect_state_e state;
        logic [1:0]  step;
    } seq_regs_t;

endpackage

// File: rtl/bss_en_decode.sv
module bss_en_decode
    import bss_pkg::*;
(
    input  logic [1:0] en_code,
    output logic       en_active,
    output logic       en_master,
    output logic       en_slaved
);

    always_comb begin
        en_active = 1'b0;
        en_master = 1'b0;
        en_slaved = 1'b0;
        case (en_code)
            EN_ON, EN_ON_B: begin
                en_active = 1'b1;
                en_master = 1'b1;
            end
            EN_SLAVE: begin
                en_active = 1'b1;
                en_slaved = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bss_step_timer.sv
module bss_step_timer #(
    parameter int unsigned STEP_CYCLES = 70000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int unsigned CW = $clog2(STEP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bss_arm_counter.sv
module bss_arm_counter #(
    parameter int unsigned ARM_TICKS = 29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic armed
);

    localparam int unsigned AW = $clog2(ARM_TICKS + 1);
    localparam logic [AW-1:0] ARM_AT = AW'(ARM_TICKS);

    logic [AW-1:0] cnt_d, cnt_q;

    always_comb begin
        armed = (cnt_q == ARM_AT);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick && !armed) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/buck_seq_supervisor.sv
module buck_seq_supervisor
    import bss_pkg::*;
#(
    parameter int unsigned STEP_CYCLES   = 70000,
    parameter int unsigned UVP_ARM_TICKS = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] en_code,
    input  logic       other_pgood,
    input  logic       ov_flag,
    input  logic       uv_flag,
    input  logic       pg_low_flag,
    input  logic       pvcc_ok,
    input  logic       ref_ok,
    input  logic       ot_flag,
    output logic [1:0] ilim_scale,
    output logic       sw_en,
    output logic       ovp_pulldown,
    output logic       dis_en,
    output logic       pgood
);

    localparam logic [1:0] LAST_STEP = SCALE_FULL;

    logic en_active, en_master, en_slaved;
    logic tick, uvp_armed, switching;
    logic supply_ok;

    seq_regs_t r_d, r_q;

    bss_en_decode u_en_dec (
        .en_code   (en_code),
        .en_active (en_active),
        .en_master (en_master),
        .en_slaved (en_slaved)
    );

    bss_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (switching),
        .tick  (tick)
    );

    bss_arm_counter #(.ARM_TICKS(UVP_ARM_TICKS)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (switching),
        .tick  (tick),
        .armed (uvp_armed)
    );

    assign switching = (r_q.state == ST_SOFT) || (r_q.state == ST_RUN);
    assign supply_ok = pvcc_ok && ref_ok;

    // Next-state logic: supplies and enable first, then latched faults,
    // then new faults in priority order, then normal sequencing.
    always_comb begin
        r_d = r_q;
        if (!en_active || !supply_ok) begin
            r_d.state = ST_OFF;
            r_d.step  = SCALE_MIN;
        end else begin
            case (r_q.state)
                ST_OVP, ST_UVP, ST_HOT: begin
                    r_d = r_q;
                end
                default: begin
                    if (ov_flag) begin
                        r_d.state = ST_OVP;
                    end else if (ot_flag) begin
                        r_d.state = ST_HOT;
                        r_d.step  = SCALE_MIN;
                    end else begin
                        case (r_q.state)
                            ST_OFF, ST_WAIT: begin
                                if (en_master || other_pgood) begin
                                    r_d.state = ST_SOFT;
                                    r_d.step  = SCALE_MIN;
                                end else begin
                                    r_d.state = ST_WAIT;
                                end
                            end
                            ST_SOFT, ST_RUN: begin
                                if (en_slaved && !other_pgood) begin
                                    r_d.state = ST_WAIT;
                                    r_d.step  = SCALE_MIN;
                                end else if (uv_flag && uvp_armed) begin
                                    r_d.state = ST_UVP;
                                    r_d.step  = SCALE_MIN;
                                end else if (r_q.state == ST_SOFT && tick) begin
                                    if (r_q.step == LAST_STEP) begin
                                        r_d.state = ST_RUN;
                                    end else begin
                                        r_d.step = r_q.step + 1'b1;
                                    end
                                end
                            end
                            default: begin
                                r_d.state = ST_OFF;
                                r_d.step  = SCALE_MIN;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.step  <= SCALE_MIN;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sw_en        = switching;
        ovp_pulldown = (r_q.state == ST_OVP);
        dis_en       = (r_q.state == ST_OFF) || (r_q.state == ST_WAIT) ||
                       (r_q.state == ST_UVP) || (r_q.state == ST_HOT);
        case (r_q.state)
            ST_SOFT:        ilim_scale = r_q.step;
            ST_RUN, ST_OVP: ilim_scale = SCALE_FULL;
            default:        ilim_scale = SCALE_MIN;
        endcase
        pgood = (r_q.state == ST_RUN) && !pg_low_flag && !ov_flag;
    end

endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] en_code,
    input logic       other_pgood,
    input logic       ov_flag,
    input logic       pg_low_flag,
    input logic       pvcc_ok,
    input logic       ref_ok,
    input logic [1:0] ilim_scale,
    input logic       sw_en,
    input logic       ovp_pulldown,
    input logic       dis_en,
    input logic       pgood
);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_code == 2'b00) |=> (!sw_en && !ovp_pulldown && dis_en));

    p_slave_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_code == 2'b10 && !other_pgood && !sw_en) |=> !sw_en);

    p_scale_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && $past(sw_en) && ilim_scale != $past(ilim_scale))
        |-> (ilim_scale == $past(ilim_scale) + 2'd1));

    p_ovp_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_pulldown && en_code != 2'b00 && pvcc_ok && ref_ok) |=> ovp_pulldown);

    p_supply_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pvcc_ok || !ref_ok) |=> (!sw_en && !ovp_pulldown && dis_en));

    p_pg_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (sw_en && !pg_low_flag && !ov_flag && ilim_scale == 2'd3));

    p_drive_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sw_en, dis_en, ovp_pulldown}) <= 1);

endmodule

bind buck_seq_supervisor bss_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_code      (en_code),
    .other_pgood  (other_pgood),
    .ov_flag      (ov_flag),
    .pg_low_flag  (pg_low_flag),
    .pvcc_ok      (pvcc_ok),
    .ref_ok       (ref_ok),
    .ilim_scale   (ilim_scale),
    .sw_en        (sw_en),
    .ovp_pulldown (ovp_pulldown),
    .dis_en       (dis_en),
    .pgood        (pgood)
);

// File: tb/buck_seq_supervisor_tb.sv
module buck_seq_supervisor_tb_top;

    localparam int unsigned STEP = 8;
    localparam int unsigned ARM  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] en_code = 2'b00;
    logic       other_pgood = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0;
    logic       pg_low_flag = 1'b0, pvcc_ok = 1'b1, ref_ok = 1'b1, ot_flag = 1'b0;
    logic [1:0] ilim_scale;
    logic       sw_en, ovp_pulldown, dis_en, pgood;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    buck_seq_supervisor #(.STEP_CYCLES(STEP), .UVP_ARM_TICKS(ARM)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_code(en_code), .other_pgood(other_pgood),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .pg_low_flag(pg_low_flag),
        .pvcc_ok(pvcc_ok), .ref_ok(ref_ok), .ot_flag(ot_flag),
        .ilim_scale(ilim_scale), .sw_en(sw_en), .ovp_pulldown(ovp_pulldown),
        .dis_en(dis_en), .pgood(pgood)
    );

    typedef struct packed {
        logic [1:0] en;
        logic       opg, ov, uv, pgl, pvcc, rok, ot;
        logic [7:0] cyc;
        logic       sw, dis, ovp, pg;
        logic [1:0] sc;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd2, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1},  // R1 idle
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd3},  // R3 25%
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd8, 1'b1,1'b0,1'b0,1'b0,2'd1,8'd3},  // R3 50%
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd8, 1'b1,1'b0,1'b0,1'b0,2'd2,8'd3},  // R3 75%
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd8, 1'b1,1'b0,1'b0,1'b0,2'd3,8'd8},  // R8 no pg in ramp
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd8, 1'b1,1'b0,1'b0,1'b1,2'd3,8'd8},  // R8 regulation
        '{2'b01,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd3,8'd8},  // R8 below 90%
        '{2'b01,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,8'd3, 1'b1,1'b0,1'b0,1'b0,2'd3,8'd4},  // R4 uv ignored
        '{2'b01,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,8'd14,1'b0,1'b1,1'b0,1'b0,2'd0,8'd6},  // R6 uvp trips
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd5, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd6},  // R6 latched
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1},  // R1 off
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd1},  // R1 cleared
        '{2'b01,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,1'b1,1'b0,2'd3,8'd5},  // R5 ov in ramp
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd5, 1'b0,1'b0,1'b1,1'b0,2'd3,8'd5},  // R5 latched
        '{2'b01,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'd2, 1'b0,1'b0,1'b1,1'b0,2'd3,8'd11}, // R11 latched wins
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1},  // R1 off
        '{2'b10,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd5, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd2},  // R2 waits
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd2},  // R2 starts
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b1,1'b0,1'b0,1'b1,2'd3,8'd2},  // R2 regulates
        '{2'b10,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd2},  // R2 follows stop
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd2},  // R2 restarts
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd7},  // R7 pvcc low
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd7},  // R7 resumes
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd10}, // R10 hot
        '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd3, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd10}, // R10 latched
        '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd10}, // R10 cleared
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd3, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd9},  // R9 ref low
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd9},  // R9 ref back
        '{2'b01,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,8'd1, 1'b0,1'b0,1'b1,1'b0,2'd3,8'd11}, // R11 ov first
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd7},  // R7 clears ovp
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd7},  // R7 restart
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1},  // R1 off
        '{2'b11,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,1'b0,2'd0,8'd1},  // R1 code 11
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1},  // R1 off
        '{2'b10,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd2},  // R2 waiting
        '{2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b0,1'b1,1'b0,2'd3,8'd5},  // R5 ov in wait
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd1, 1'b0,1'b1,1'b0,1'b0,2'd0,8'd1}   // R1 off
    };

    task automatic check_out(input string tag, input logic sw, input logic dis,
                             input logic ovp, input logic pg, input logic [1:0] sc);
        checks++;
        if (sw_en !== sw || dis_en !== dis || ovp_pulldown !== ovp ||
            pgood !== pg || ilim_scale !== sc) begin
            errors++;
            $display("FAIL %s: got sw=%b dis=%b ovp=%b pg=%b sc=%0d, expected sw=%b dis=%b ovp=%b pg=%b sc=%0d",
                     tag, sw_en, dis_en, ovp_pulldown, pgood, ilim_scale,
                     sw, dis, ovp, pg, sc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_out("R1 reset", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            en_code = VECS[i].en;  other_pgood = VECS[i].opg;
            ov_flag = VECS[i].ov;  uv_flag = VECS[i].uv;
            pg_low_flag = VECS[i].pgl; pvcc_ok = VECS[i].pvcc;
            ref_ok = VECS[i].rok;  ot_flag = VECS[i].ot;
            repeat (int'(VECS[i].cyc) - 1) @(negedge clk);
            @(negedge clk);
            check_out($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].sw, VECS[i].dis, VECS[i].ovp, VECS[i].pg, VECS[i].sc);
        end

        // R4: exact arming boundary (arms on the sixth step tick)
        @(negedge clk);
        en_code = 2'b01;
        repeat (47) @(negedge clk);
        uv_flag = 1'b1;
        @(negedge clk);
        check_out("R4 before arming", 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);
        uv_flag = 1'b0;
        @(negedge clk);
        uv_flag = 1'b1;
        @(negedge clk);
        check_out("R4 after arming", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        uv_flag = 1'b0;

        // R3: restart after fault clear begins from 25% again
        en_code = 2'b00;
        @(negedge clk);
        en_code = 2'b01;
        repeat (8) @(negedge clk);
        check_out("R3 last 25% cycle", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        check_out("R3 first 50% cycle", 1'b1, 1'b0, 1'b0, 1'b0, 2'd1);

        // R1: reset mid-ramp returns to idle
        rst_n = 1'b0;
        en_code = 2'b00;
        @(negedge clk);
        check_out("R1 mid reset", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule